// File: doc/BRIEF.md
# Power Controller Configuration Register Slave

This block is the two-wire serial (I2C-compatible) target that holds the settings of a multi-rail display power controller. It recognises a 7-bit device address whose six upper bits are fixed and whose lowest bit comes from a strap pin. It accepts single-byte and multi-byte writes. Reads work by first writing a register pointer and then issuing a repeated start with the read bit set. The register pointer advances by one after every data byte in both directions.

Each register has its own legal code range. A value outside that range is not stored as written: the register falls back to its reset default. The current settings are driven in parallel as registered outputs to the sequencing and regulation logic. Writing the key value 55h to the control register at FFh raises a one-cycle sequence-start pulse. Both bus lines are sampled through synchronisers on the system clock. The data line is driven open-drain through an output-enable.

Top module: `pcfg_i2c_slave`

## Requirements
- R1: The block answers only to a device address byte whose upper seven bits are 110100 followed by the `addr_sel` level (bit 0 of the byte is R/W, 1 = read). Any other address is left unacknowledged, and the block stays silent until the next start.
- R2: The block acknowledges the matching address byte, the register-pointer byte and every written data byte by pulling SDA low through the ninth clock.
- R3: After reset the settings are: 00h=1Dh, 01h=16h, 02h=2Ah, 03h=07h, 04h=07h, 05h=01h, 06h=02h, 07h=01h, 08h=02h, 09h=02h, 0Ah=01h, 0Bh=02h, 0Ch=00h, FFh=00h. SDA is released.
- R4: In a multi-byte write the first data byte goes to the addressed register, and each further byte goes to the next address.
- R5: A read (pointer write, repeated start, address with R/W=1) returns the register at the pointer, MSB first. It continues with the following addresses for as long as the master acknowledges.
- R6: The legal maxima are 00h:3Fh, 01h:1Fh, 02h:3Fh, 03h/04h:0Eh, 05h–07h:0Fh, 08h–0Ah:02h, 0Bh/0Ch:0Fh. A larger written byte loads the register's default. The register's parallel output never holds an illegal code.
- R7: A write to an unmapped address (0Dh–FEh) is acknowledged and changes nothing. A read from one returns 00h.
- R8: Writing 55h to FFh gives exactly one single-cycle `seq_start` pulse. Any other value gives none. FFh reads back the last value written.
- R9: SDA is only ever pulled low, never driven high. The enable rises only while SCL is low.
- R10: A master NACK ends a read. A stop returns the block to idle with SDA released, and the next transaction works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 1 | Strap for device address bit 0 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| boost_code | output | 6 | Register 00h: boost rail code |
| gate_hi_code | output | 5 | Register 01h: positive gate rail code |
| gate_lo_code | output | 6 | Register 02h: negative gate rail code |
| io_trim | output | 4 | Register 03h: logic rail trim |
| core_trim | output | 4 | Register 04h: core rail trim |
| dly_a | output | 4 | Register 05h: first delay count |
| dly_b | output | 4 | Register 06h: second delay count |
| dly_c | output | 4 | Register 07h: third delay count |
| dres_a | output | 2 | Register 08h: first delay step select |
| dres_b | output | 2 | Register 09h: second delay step select |
| dres_c | output | 2 | Register 0Ah: third delay step select |
| soft_start | output | 4 | Register 0Bh: boost ramp time |
| isw_limit | output | 4 | Register 0Ch: isolation switch limit |
| seq_start | output | 1 | One-cycle pulse on key write to FFh |

## Verification
The assertions check on every cycle that the trim and step-select outputs never hold an out-of-range code, that the start pulse never lasts two cycles, that the open-drain enable only rises while the clock line is low, and that the defaults appear right after reset. Address matching, acknowledge timing, pointer auto-increment across bursts, fallback to defaults, the silence of unmapped addresses and the NACK-terminated read can only be shown by the bench's bus transactions, which compare every output and read-back byte against a model of the register rules.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int         NUM_REGS  = 13;
  localparam logic [7:0] CTRL_ADDR = 8'hFF;
  localparam logic [7:0] START_KEY = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_WR, ST_RD, ST_RACK
  } bus_state_t;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h1D;
      1:       return 8'h16;
      2:       return 8'h2A;
      3, 4:    return 8'h07;
      5, 7:    return 8'h01;
      6:       return 8'h02;
      8, 9:    return 8'h02;
      10:      return 8'h01;
      11:      return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_limit(input int idx);
    case (idx)
      0, 2:     return 8'h3F;
      1:        return 8'h1F;
      3, 4:     return 8'h0E;
      8, 9, 10: return 8'h02;
      5, 6, 7, 11, 12: return 8'h0F;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pcfg_sync.sv
module pcfg_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pcfg_bus_engine.sv
module pcfg_bus_engine
  import pcfg_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b110100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       addr_sel,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  bus_state_t state;
  logic       scl_d, sda_d;
  logic [3:0] cnt;
  logic [7:0] sh, txd;
  logic       ack_on, rw, mack;

  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; scl_d <= 1'b1; sda_d <= 1'b1;
      cnt <= '0; sh <= '0; txd <= '0; ack_on <= 1'b0; rw <= 1'b0;
      mack <= 1'b0; sda_oe <= 1'b0; ptr <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      wr_en <= 1'b0;
      if (start_c) begin
        state <= ST_DEV; cnt <= '0; ack_on <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        state <= ST_IDLE; ack_on <= 1'b0; sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (state)
          ST_DEV, ST_REG, ST_WR:
            if (!ack_on) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end
          ST_RD:   cnt  <= cnt + 4'd1;
          ST_RACK: mack <= ~sda_s;
          default: ;
        endcase
      end else if (scl_fall) begin
        if (ack_on) begin
          ack_on <= 1'b0; sda_oe <= 1'b0; cnt <= '0;
          if (state == ST_DEV) begin
            if (rw) begin
              state  <= ST_RD;
              txd    <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state <= ST_REG;
            end
          end else if (state == ST_REG) begin
            state <= ST_WR;
          end
        end else begin
          case (state)
            ST_DEV:
              if (cnt == 4'd8) begin
                if (sh[7:1] == {ADDR_HI, addr_sel}) begin
                  rw <= sh[0]; ack_on <= 1'b1; sda_oe <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end
            ST_REG:
              if (cnt == 4'd8) begin
                ptr <= sh; ack_on <= 1'b1; sda_oe <= 1'b1;
              end
            ST_WR:
              if (cnt == 4'd8) begin
                wr_en <= 1'b1; wr_addr <= ptr; wr_data <= sh;
                ptr <= ptr + 8'd1; ack_on <= 1'b1; sda_oe <= 1'b1;
              end
            ST_RD:
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; state <= ST_RACK; ptr <= ptr + 8'd1;
              end else begin
                sda_oe <= ~txd[3'd7 - cnt[2:0]];
              end
            ST_RACK:
              if (mack) begin
                state <= ST_RD; cnt <= '0; txd <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                state <= ST_IDLE;
              end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pcfg_regfile.sv
module pcfg_regfile
  import pcfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [7:0]                wr_addr,
  input  logic [7:0]                wr_data,
  input  logic [7:0]                rd_addr,
  output logic [7:0]                rd_data,
  output logic [NUM_REGS-1:0][7:0]  regs_q,
  output logic                      seq_start
);
  logic [7:0] ctrl_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= reg_default(g);
      end else if (wr_en && wr_addr == 8'(g)) begin
        q <= (wr_data > reg_limit(g)) ? reg_default(g) : wr_data;
      end
    end
    assign regs_q[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= 8'h00;
      seq_start <= 1'b0;
    end else begin
      seq_start <= wr_en && wr_addr == CTRL_ADDR && wr_data == START_KEY;
      if (wr_en && wr_addr == CTRL_ADDR) ctrl_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == CTRL_ADDR) rd_data = ctrl_q;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == 8'(i)) rd_data = regs_q[i];
    end
  end
endmodule

// File: rtl/pcfg_i2c_slave.sv
module pcfg_i2c_slave
  import pcfg_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b110100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  output logic       sda_oe,
  output logic [5:0] boost_code,
  output logic [4:0] gate_hi_code,
  output logic [5:0] gate_lo_code,
  output logic [3:0] io_trim,
  output logic [3:0] core_trim,
  output logic [3:0] dly_a,
  output logic [3:0] dly_b,
  output logic [3:0] dly_c,
  output logic [1:0] dres_a,
  output logic [1:0] dres_b,
  output logic [1:0] dres_c,
  output logic [3:0] soft_start,
  output logic [3:0] isw_limit,
  output logic       seq_start
);
  logic scl_s, sda_s;
  logic [7:0] ptr, rd_data, wr_addr, wr_data;
  logic wr_en;
  logic [NUM_REGS-1:0][7:0] regs_q;

  pcfg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_scl_sync (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
  pcfg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_sda_sync (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

  pcfg_bus_engine #(.ADDR_HI(DEV_ADDR_HI)) i_engine (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .addr_sel(addr_sel),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data));

  pcfg_regfile i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
    .regs_q(regs_q), .seq_start(seq_start));

  assign boost_code   = regs_q[0][5:0];
  assign gate_hi_code = regs_q[1][4:0];
  assign gate_lo_code = regs_q[2][5:0];
  assign io_trim      = regs_q[3][3:0];
  assign core_trim    = regs_q[4][3:0];
  assign dly_a        = regs_q[5][3:0];
  assign dly_b        = regs_q[6][3:0];
  assign dly_c        = regs_q[7][3:0];
  assign dres_a       = regs_q[8][1:0];
  assign dres_b       = regs_q[9][1:0];
  assign dres_c       = regs_q[10][1:0];
  assign soft_start   = regs_q[11][3:0];
  assign isw_limit    = regs_q[12][3:0];

  logic unused_hi;
  assign unused_hi = ^{regs_q[0][7:6], regs_q[1][7:5], regs_q[2][7:6],
                       regs_q[3][7:4], regs_q[4][7:4], regs_q[5][7:4],
                       regs_q[6][7:4], regs_q[7][7:4], regs_q[8][7:2],
                       regs_q[9][7:2], regs_q[10][7:2], regs_q[11][7:4],
                       regs_q[12][7:4]};
endmodule

// File: rtl/pcfg_checker.sv
module pcfg_checker (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       seq_start,
  input logic [5:0] boost_code,
  input logic [4:0] gate_hi_code,
  input logic [3:0] io_trim,
  input logic [3:0] core_trim,
  input logic [1:0] dres_a,
  input logic [1:0] dres_b,
  input logic [1:0] dres_c
);
  a_r3_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (boost_code == 6'h1D && gate_hi_code == 5'h16 && !sda_oe));

  a_r6_trim_legal: assert property (@(posedge clk) disable iff (rst)
    (io_trim <= 4'hE && core_trim <= 4'hE));

  a_r6_step_legal: assert property (@(posedge clk) disable iff (rst)
    (dres_a <= 2'd2 && dres_b <= 2'd2 && dres_c <= 2'd2));

  a_r8_start_single: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start);

  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind pcfg_i2c_slave pcfg_checker i_checker (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .seq_start(seq_start), .boost_code(boost_code),
  .gate_hi_code(gate_hi_code), .io_trim(io_trim), .core_trim(core_trim),
  .dres_a(dres_a), .dres_b(dres_b), .dres_c(dres_c));

// File: tb/test_pcfg_i2c_slave.sv
module test_pcfg_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b1;
  logic sda_oe, seq_start;
  logic [5:0] boost_code, gate_lo_code;
  logic [4:0] gate_hi_code;
  logic [3:0] io_trim, core_trim, dly_a, dly_b, dly_c, soft_start, isw_limit;
  logic [1:0] dres_a, dres_b, dres_c;
  wire sda_line = sda_m & ~sda_oe;

  int n_tests = 0, n_fail = 0, pulses = 0, long_pulse = 0;
  bit done = 1'b0, prev_pulse = 1'b0;
  logic [7:0] model [256];
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcfg_i2c_slave i_pcfg_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .boost_code(boost_code), .gate_hi_code(gate_hi_code),
    .gate_lo_code(gate_lo_code), .io_trim(io_trim), .core_trim(core_trim),
    .dly_a(dly_a), .dly_b(dly_b), .dly_c(dly_c), .dres_a(dres_a),
    .dres_b(dres_b), .dres_c(dres_c), .soft_start(soft_start),
    .isw_limit(isw_limit), .seq_start(seq_start));

  always @(posedge clk) begin
    if (seq_start) pulses++;
    if (seq_start && prev_pulse) long_pulse++;
    prev_pulse <= seq_start;
  end

  function automatic logic [7:0] tb_default(input int a);
    logic [7:0] t [13] = '{8'h1D, 8'h16, 8'h2A, 8'h07, 8'h07, 8'h01, 8'h02,
                           8'h01, 8'h02, 8'h02, 8'h01, 8'h02, 8'h00};
    return (a < 13) ? t[a] : 8'h00;
  endfunction

  function automatic logic [7:0] tb_limit(input int a);
    logic [7:0] t [13] = '{8'h3F, 8'h1F, 8'h3F, 8'h0E, 8'h0E, 8'h0F, 8'h0F,
                           8'h0F, 8'h02, 8'h02, 8'h02, 8'h0F, 8'h0F};
    return t[a];
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    if (a < 13) model[a] = (d > tb_limit(a)) ? tb_default(a) : d;
    else if (a == 255) model[a] = d;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    chk(req, "boost", boost_code, model[0]);
    chk(req, "gate_hi", gate_hi_code, model[1]);
    chk(req, "gate_lo", gate_lo_code, model[2]);
    chk(req, "io_trim", io_trim, model[3]);
    chk(req, "core_trim", core_trim, model[4]);
    chk(req, "dly", {dly_a, dly_b, dly_c}, {model[5][3:0], model[6][3:0], model[7][3:0]});
    chk(req, "dres", {dres_a, dres_b, dres_c}, {model[8][1:0], model[9][1:0], model[10][1:0]});
    chk(req, "soft_start", soft_start, model[11]);
    chk(req, "isw_limit", isw_limit, model[12]);
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_h(H); scl_m = 1'b1; wait_h(H);
    sda_m = 1'b0; wait_h(H); scl_m = 1'b0; wait_h(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_h(H); scl_m = 1'b1; wait_h(H); sda_m = 1'b1; wait_h(2*H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_h(H); scl_m = 1'b1; wait_h(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; wait_h(H); scl_m = 1'b1; wait_h(H/2);
    ack = ~sda_line;
    wait_h(H/2); scl_m = 1'b0;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_h(H); scl_m = 1'b1; wait_h(H/2); b[i] = sda_line;
      wait_h(H/2); scl_m = 1'b0;
    end
    sda_m = ~mack; wait_h(H); scl_m = 1'b1; wait_h(H); scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {6'b110100, addr_sel, rw};
  endfunction

  task automatic do_write(input logic [7:0] a, input int n, input string req);
    logic ack;
    bus_start();
    send_byte(dev(1'b0), ack); chk("R2", "dev ack", ack, 1);
    send_byte(a, ack);         chk("R2", "ptr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); chk(req, "data ack", ack, 1);
      model_write(int'(a + 8'(i)), wbuf[i]);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input string req);
    logic ack;
    bus_start();
    send_byte(dev(1'b0), ack); chk(req, "rd dev ack", ack, 1);
    send_byte(a, ack);         chk(req, "rd ptr ack", ack, 1);
    bus_start();
    send_byte(dev(1'b1), ack); chk(req, "rd dev2 ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, rbuf[i]);
      chk(req, "read data", rbuf[i], model[8'(a + 8'(i))]);
    end
    bus_stop();
    chk("R10", "oe idle after stop", sda_oe, 0);
  endtask

  initial begin
    logic ack;
    int p0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) model[i] = tb_default(i);
    wait_h(5); rst = 1'b0; wait_h(2);
    chk_outputs("R3");
    chk("R3", "oe after reset", sda_oe, 0);

    // R1: wrong address ignored, then correct address acknowledged
    bus_start(); send_byte(8'hD0, ack); chk("R1", "foreign addr nack", ack, 0);
    chk("R1", "no drive", sda_oe, 0); bus_stop();
    wbuf[0] = 8'h0F; do_write(8'h03, 1, "R2");
    chk("R6", "io_trim fallback", io_trim, 4'h7);
    wbuf[0] = 8'h0A; do_write(8'h04, 1, "R6");
    chk("R6", "core_trim legal", core_trim, 4'hA);
    wbuf[0] = 8'h03; wbuf[1] = 8'h00; wbuf[2] = 8'h05; do_write(8'h08, 3, "R6");
    chk("R6", "dres fallback", {dres_a, dres_b, dres_c}, {2'd2, 2'd0, 2'd1});
    wbuf[0] = 8'h40; do_write(8'h00, 1, "R6");
    chk("R6", "boost fallback", boost_code, 6'h1D);

    // R4: burst write
    wbuf[0] = 8'h3; wbuf[1] = 8'h4; wbuf[2] = 8'h5; do_write(8'h05, 3, "R4");
    chk("R4", "burst dly", {dly_a, dly_b, dly_c}, 12'h345);
    chk_outputs("R4");

    // R5: burst read
    do_read(8'h00, 4, "R5");
    do_read(8'h09, 3, "R5");

    // R7: unmapped, and burst crossing the map end
    wbuf[0] = 8'hAB; do_write(8'h30, 1, "R7");
    do_read(8'h30, 1, "R7");
    wbuf[0] = 8'h05; wbuf[1] = 8'h77; do_write(8'h0C, 2, "R7");
    chk("R7", "isw_limit", isw_limit, 4'h5);
    do_read(8'h0C, 2, "R7");
    chk_outputs("R7");

    // R8: sequence start key
    p0 = pulses;
    wbuf[0] = 8'h54; do_write(8'hFF, 1, "R8");
    chk("R8", "no pulse on wrong key", pulses - p0, 0);
    wbuf[0] = 8'h55; do_write(8'hFF, 1, "R8");
    chk("R8", "one pulse on key", pulses - p0, 1);
    chk("R8", "pulse width", long_pulse, 0);
    do_read(8'hFF, 1, "R8");

    // R1: other strap level
    addr_sel = 1'b0;
    bus_start(); send_byte(8'hD2, ack); chk("R1", "old addr nack", ack, 0); bus_stop();
    do_read(8'h02, 2, "R1");

    // random transactions, R9 / R10 observed through every transaction
    for (int it = 0; it < 25; it++) begin
      int a = $urandom_range(0, 15);
      int n = $urandom_range(1, 3);
      for (int k = 0; k < n; k++) begin
        int t = (a + k < 13) ? a + k : 12;
        wbuf[k] = $urandom_range(0, 1) ? 8'($urandom_range(0, int'(tb_limit(t))))
                                        : 8'($urandom_range(0, 255));
      end
      do_write(8'(a), n, "R4");
      do_read(8'(a), n, "R5");
      chk_outputs("R6");
    end
    chk("R9", "oe released at end", sda_oe, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule